// File: doc/BRIEF.md
# Configuration Port Decoder

This block sits on the host side of a bus bridge and turns processor I/O-port accesses into configuration requests on a simple internal configuration bus. It can decode either of two access schemes. The first is an address-register scheme: a 32-bit address register sets the target, and a four-byte data window then reaches that target. The second is a windowed scheme: a byte-wide key/function register and a bus-forward register open a 4 KB I/O window, and each 256-byte slice of that window maps to one device.

The scheme is chosen by an input that is sampled only while reset is held. The block serves one access at a time. An I/O access is a single-cycle `io_req` pulse. It ends with a single-cycle `io_done` pulse, which carries the read value. `io_pass` is raised with `io_done` when the access does not belong to the decoder and must be treated as ordinary I/O. Write data and read data use byte-lane positions: byte lane n sits in data bits 8n+7:8n. The decoder does no shifting.

Top module: `cfg_port_decoder`

## Requirements
- R1: `mech2_sel` is sampled only while `rst_n` is low (0 = address-register scheme, 1 = windowed scheme). Changing it later has no effect. Addresses that only the other scheme uses pass through: in the windowed scheme a 32-bit access at 0xCF8 passes, and in the address-register scheme 0xC000–0xCFFF passes.
- R2: In the address-register scheme, a 32-bit access (`io_size`=2) at 0xCF8 reads or writes the address register. Bits 30:24 always read as zero, and the register reads 0 after reset.
- R3: A byte or 16-bit access anywhere in 0xCF8–0xCFB, in the address-register scheme, passes through and leaves the address register unchanged.
- R4: With address bit 31 set, an access to 0xCFC–0xCFF issues a request with bus = bits 23:16, device = 15:11, function = 10:8 and register = bits 7:2 with bits 1:0 cleared. Byte enables are one-hot from address bits 1:0 for a byte access, 0011 or 1100 from address bit 1 for a 16-bit access, and 1111 for a 32-bit access. With bit 31 clear the access passes through.
- R5: `cfg_type` is 1 exactly when the target bus is nonzero.
- R6: A target device above the scheme's device limit (`M1_DEV_MAX` or `M2_DEV_MAX`) issues no request. It completes the cycle after `io_req`, returning all ones for a read.
- R7: In the windowed scheme, a byte access at 0xCF8 reaches the key/function register (data lane 0), and a byte access at 0xCFA reaches the bus-forward register (lane 2). Both read 0 after reset.
- R8: While the key (bits 7:4 of the key/function register) is nonzero, an access in 0xC000–0xCFFF issues a request. The bus comes from the forward register, the device from address bits 11:8, the function from key register bits 3:1, and the register number and enables follow the R4 rules. The two byte registers take priority over the window.
- R9: While the key is zero, window accesses pass through, and so does any other access in 0xCF8–0xCFB.
- R10: A request is held until `cfg_ack`. `io_done` follows in the next cycle, with `cfg_rdata` for a read and 0 for a write, and the request drops.
- R11: A request not acknowledged within `TIMEOUT` cycles is dropped after exactly `TIMEOUT` cycles high, and a read then returns all ones.
- R12: Every request field stays stable for as long as `cfg_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mech2_sel | input | 1 | Scheme select, sampled during reset |
| io_req | input | 1 | Single-cycle access strobe |
| io_wr | input | 1 | 1 = write |
| io_addr | input | 16 | I/O byte address |
| io_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| io_wdata | input | 32 | Lane-positioned write data |
| io_done | output | 1 | Access complete pulse |
| io_pass | output | 1 | Access not claimed, pass through |
| io_rdata | output | 32 | Lane-positioned read data |
| cfg_req | output | 1 | Configuration request |
| cfg_wr | output | 1 | Request is a write |
| cfg_type | output | 1 | 0 local bus, 1 forwarded bus |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_fn | output | 3 | Target function |
| cfg_reg | output | 8 | Dword-aligned register number |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data |
| cfg_ack | input | 1 | Request completion |
| cfg_rdata | input | 32 | Read data with the ack |

## Verification
The checker watches every cycle for these properties of a live request:
- the fields stay stable and the register number stays dword aligned;
- the type bit agrees with the bus number;
- the device never exceeds the active scheme's limit;
- a request never stays high longer than the timeout;
- an acknowledged request is followed by `io_done`.

Other behaviour can only be shown by the bench's access sequences. This covers the decoding of each address (claim or pass), the register contents surviving narrow writes, the key opening and closing the window, the reset-time latch of the scheme select, and the read values returned after an ack, a timeout or an out-of-range device.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

   typedef enum logic [1:0] {
      ACC_PASS  = 2'd0,
      ACC_REG   = 2'd1,
      ACC_CFG   = 2'd2,
      ACC_NODEV = 2'd3
   } acc_kind_e;

   localparam logic [1:0] SZ_BYTE  = 2'd0;
   localparam logic [1:0] SZ_WORD  = 2'd1;
   localparam logic [1:0] SZ_DWORD = 2'd2;

   // port block 0xCF8..0xCFB and data block 0xCFC..0xCFF as dword indices
   localparam logic [13:0] PORT_DW = 14'h33E;
   localparam logic [13:0] DATA_DW = 14'h33F;

   typedef struct packed {
      acc_kind_e   kind;
      logic [7:0]  bus;
      logic [4:0]  dev;
      logic [2:0]  fn;
      logic [7:0]  regno;
      logic [3:0]  be;
      logic [31:0] rval;
   } dec_t;

   function automatic logic [3:0] lane_be(input logic [1:0] sz, input logic [1:0] a);
      logic [3:0] r;
      case (sz)
         SZ_BYTE: r = 4'b0001 << a;
         SZ_WORD: r = a[1] ? 4'b1100 : 4'b0011;
         default: r = 4'b1111;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cfgdec_mech1.sv
module cfgdec_mech1
   import cfgdec_pkg::*;
#(
   parameter int DEV_MAX = 31
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic        wr,
   input  logic [15:0] addr,
   input  logic [1:0]  size,
   input  logic [31:0] wdata,
   output dec_t        dec
);
   localparam logic [4:0]  DLIM = 5'(DEV_MAX);
   localparam logic [31:0] KEEP = 32'h80FF_FFFF;

   logic [31:0] areg;
   logic        at_port, at_data, full;

   assign at_port = (addr[15:2] == PORT_DW);
   assign at_data = (addr[15:2] == DATA_DW);
   assign full    = (size == SZ_DWORD) || (size == 2'd3);

   always_comb begin
      dec = '0;
      dec.kind = ACC_PASS;
      if (at_port && full) begin
         dec.kind = ACC_REG;
         dec.rval = areg;
      end else if (at_data && areg[31]) begin
         dec.bus   = areg[23:16];
         dec.dev   = areg[15:11];
         dec.fn    = areg[10:8];
         dec.regno = {areg[7:2], 2'b00};
         dec.be    = lane_be(size, addr[1:0]);
         dec.kind  = (areg[15:11] > DLIM) ? ACC_NODEV : ACC_CFG;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         areg <= '0;
      else if (load && wr && at_port && full)
         areg <= wdata & KEEP;
   end

endmodule

// File: rtl/cfgdec_mech2.sv
module cfgdec_mech2
   import cfgdec_pkg::*;
#(
   parameter int DEV_MAX = 15
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic        wr,
   input  logic [15:0] addr,
   input  logic [1:0]  size,
   input  logic [7:0]  wbyte0,
   input  logic [7:0]  wbyte2,
   output dec_t        dec
);
   localparam logic [4:0] DLIM = 5'(DEV_MAX);

   logic [7:0] keyfn;
   logic [7:0] fwd;
   logic       at_key, at_fwd, in_port, in_win;

   assign at_key  = (addr == 16'hCF8) && (size == SZ_BYTE);
   assign at_fwd  = (addr == 16'hCFA) && (size == SZ_BYTE);
   assign in_port = (addr[15:2] == PORT_DW);
   assign in_win  = (addr[15:12] == 4'hC) && (keyfn[7:4] != 4'h0);

   always_comb begin
      dec = '0;
      dec.kind = ACC_PASS;
      if (at_key) begin
         dec.kind = ACC_REG;
         dec.rval = {24'h0, keyfn};
      end else if (at_fwd) begin
         dec.kind = ACC_REG;
         dec.rval = {8'h0, fwd, 16'h0};
      end else if (in_port) begin
         dec.kind = ACC_PASS;
      end else if (in_win) begin
         dec.bus   = fwd;
         dec.dev   = {1'b0, addr[11:8]};
         dec.fn    = keyfn[3:1];
         dec.regno = {addr[7:2], 2'b00};
         dec.be    = lane_be(size, addr[1:0]);
         dec.kind  = ({1'b0, addr[11:8]} > DLIM) ? ACC_NODEV : ACC_CFG;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         keyfn <= '0;
         fwd   <= '0;
      end else if (load && wr) begin
         if (at_key) keyfn <= wbyte0;
         if (at_fwd) fwd   <= wbyte2;
      end
   end

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
   import cfgdec_pkg::*;
#(
   parameter int TIMEOUT    = 16,
   parameter int M1_DEV_MAX = 31,
   parameter int M2_DEV_MAX = 15,
   parameter bit ENABLE_M2  = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        mech2_sel,
   input  logic        io_req,
   input  logic        io_wr,
   input  logic [15:0] io_addr,
   input  logic [1:0]  io_size,
   input  logic [31:0] io_wdata,
   output logic        io_done,
   output logic        io_pass,
   output logic [31:0] io_rdata,
   output logic        cfg_req,
   output logic        cfg_wr,
   output logic        cfg_type,
   output logic [7:0]  cfg_bus,
   output logic [4:0]  cfg_dev,
   output logic [2:0]  cfg_fn,
   output logic [7:0]  cfg_reg,
   output logic [3:0]  cfg_be,
   output logic [31:0] cfg_wdata,
   input  logic        cfg_ack,
   input  logic [31:0] cfg_rdata
);
   localparam int TW = $clog2(TIMEOUT) + 1;
   localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);

   if (TIMEOUT < 2 || TIMEOUT > 4096) begin : g_bad_timeout
      $error("TIMEOUT out of range");
   end
   if (M1_DEV_MAX < 0 || M1_DEV_MAX > 31) begin : g_bad_m1
      $error("M1_DEV_MAX out of range");
   end
   if (M2_DEV_MAX < 0 || M2_DEV_MAX > 15) begin : g_bad_m2
      $error("M2_DEV_MAX out of range");
   end

   logic          sel_q;
   logic          busy;
   logic [TW-1:0] tmr;
   logic          accept;
   dec_t          d1, d2, dsel;

   assign accept = io_req && !busy;

   cfgdec_mech1 #(.DEV_MAX(M1_DEV_MAX)) u_m1 (
      .clk(clk), .rst_n(rst_n), .load(accept && !sel_q), .wr(io_wr),
      .addr(io_addr), .size(io_size), .wdata(io_wdata), .dec(d1)
   );

   if (ENABLE_M2) begin : g_m2
      cfgdec_mech2 #(.DEV_MAX(M2_DEV_MAX)) u_m2 (
         .clk(clk), .rst_n(rst_n), .load(accept && sel_q), .wr(io_wr),
         .addr(io_addr), .size(io_size), .wbyte0(io_wdata[7:0]),
         .wbyte2(io_wdata[23:16]), .dec(d2)
      );
   end else begin : g_no_m2
      always_comb begin
         d2 = '0;
         d2.kind = ACC_PASS;
      end
   end

   assign dsel = sel_q ? d2 : d1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q     <= mech2_sel;
         busy      <= 1'b0;
         tmr       <= '0;
         io_done   <= 1'b0;
         io_pass   <= 1'b0;
         io_rdata  <= '0;
         cfg_req   <= 1'b0;
         cfg_wr    <= 1'b0;
         cfg_type  <= 1'b0;
         cfg_bus   <= '0;
         cfg_dev   <= '0;
         cfg_fn    <= '0;
         cfg_reg   <= '0;
         cfg_be    <= '0;
         cfg_wdata <= '0;
      end else begin
         io_done <= 1'b0;
         io_pass <= 1'b0;
         if (busy) begin
            if (cfg_ack) begin
               busy     <= 1'b0;
               cfg_req  <= 1'b0;
               io_done  <= 1'b1;
               io_rdata <= cfg_wr ? '0 : cfg_rdata;
            end else if (tmr == TLAST) begin
               busy     <= 1'b0;
               cfg_req  <= 1'b0;
               io_done  <= 1'b1;
               io_rdata <= cfg_wr ? '0 : '1;
            end else begin
               tmr <= tmr + 1'b1;
            end
         end else if (io_req) begin
            case (dsel.kind)
               ACC_CFG: begin
                  busy      <= 1'b1;
                  tmr       <= '0;
                  cfg_req   <= 1'b1;
                  cfg_wr    <= io_wr;
                  cfg_type  <= (dsel.bus != 8'h00);
                  cfg_bus   <= dsel.bus;
                  cfg_dev   <= dsel.dev;
                  cfg_fn    <= dsel.fn;
                  cfg_reg   <= dsel.regno;
                  cfg_be    <= dsel.be;
                  cfg_wdata <= io_wdata;
               end
               ACC_REG: begin
                  io_done  <= 1'b1;
                  io_rdata <= io_wr ? '0 : dsel.rval;
               end
               ACC_NODEV: begin
                  io_done  <= 1'b1;
                  io_rdata <= io_wr ? '0 : '1;
               end
               default: begin
                  io_done  <= 1'b1;
                  io_pass  <= 1'b1;
                  io_rdata <= '0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/cfg_port_decoder_chk.sv
module cfg_port_decoder_chk #(
   parameter int TIMEOUT    = 16,
   parameter int M1_DEV_MAX = 31,
   parameter int M2_DEV_MAX = 15
)(
   input logic        clk,
   input logic        rst_n,
   input logic        mech2_q,
   input logic        io_done,
   input logic        cfg_req,
   input logic        cfg_ack,
   input logic        cfg_wr,
   input logic        cfg_type,
   input logic [7:0]  cfg_bus,
   input logic [4:0]  cfg_dev,
   input logic [2:0]  cfg_fn,
   input logic [7:0]  cfg_reg,
   input logic [3:0]  cfg_be,
   input logic [31:0] cfg_wdata
);
   localparam int CW = $clog2(TIMEOUT) + 2;
   logic [CW-1:0] held;

   always_ff @(posedge clk) begin
      if (!rst_n || !cfg_req) held <= '0;
      else                    held <= held + 1'b1;
   end

   // R12
   fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req && $past(cfg_req) |-> $stable({cfg_wr, cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_be, cfg_wdata}));

   // R4
   reg_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> (cfg_reg[1:0] == 2'b00) && (cfg_be != 4'h0));

   // R5
   type_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> (cfg_type == (cfg_bus != 8'h00)));

   // R6
   dev_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> (int'(cfg_dev) <= (mech2_q ? M2_DEV_MAX : M1_DEV_MAX)));

   // R10
   ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req && cfg_ack |=> io_done && !cfg_req);

   // R11
   timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> (int'(held) < TIMEOUT));

   // R11
   timeout_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_req) |-> io_done);

endmodule

bind cfg_port_decoder cfg_port_decoder_chk #(
   .TIMEOUT(TIMEOUT), .M1_DEV_MAX(M1_DEV_MAX), .M2_DEV_MAX(M2_DEV_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mech2_q(sel_q), .io_done(io_done),
   .cfg_req(cfg_req), .cfg_ack(cfg_ack), .cfg_wr(cfg_wr), .cfg_type(cfg_type),
   .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_reg(cfg_reg),
   .cfg_be(cfg_be), .cfg_wdata(cfg_wdata)
);

// File: tb/cfg_port_decoder_test.sv
module cfg_port_decoder_test;
   localparam int TO  = 16;
   localparam int D1M = 20;
   localparam int D2M = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mech2_sel = 1'b0;
   logic io_req = 1'b0, io_wr = 1'b0;
   logic [15:0] io_addr = '0;
   logic [1:0]  io_size = '0;
   logic [31:0] io_wdata = '0;
   logic io_done, io_pass;
   logic [31:0] io_rdata;
   logic cfg_req, cfg_wr, cfg_type;
   logic [7:0] cfg_bus, cfg_reg;
   logic [4:0] cfg_dev;
   logic [2:0] cfg_fn;
   logic [3:0] cfg_be;
   logic [31:0] cfg_wdata;
   logic cfg_ack = 1'b0;
   logic [31:0] cfg_rdata = '0;

   int total = 0, bad = 0;
   bit m2 = 0;
   logic [31:0] m_areg;
   logic [7:0]  m_key, m_fwd;
   logic        g_pass;
   logic [31:0] g_rd;
   int          g_n;

   always #10 clk = ~clk;

   cfg_port_decoder #(.TIMEOUT(TO), .M1_DEV_MAX(D1M), .M2_DEV_MAX(D2M)) uut (
      .clk(clk), .rst_n(rst_n), .mech2_sel(mech2_sel), .io_req(io_req), .io_wr(io_wr),
      .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata), .io_done(io_done),
      .io_pass(io_pass), .io_rdata(io_rdata), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
      .cfg_type(cfg_type), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn),
      .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
      .cfg_rdata(cfg_rdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] be_of(input logic [1:0] sz, input logic [1:0] a);
      if (sz == 2'd0) return 4'b0001 << a;
      if (sz == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
      return 4'b1111;
   endfunction

   task automatic do_reset(input bit sel);
      @(negedge clk);
      rst_n = 1'b0; mech2_sel = sel; m2 = sel;
      m_areg = '0; m_key = '0; m_fwd = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      chk(!io_done && !cfg_req, "R10 idle after reset", {io_done, cfg_req}, 0);
   endtask

   // kind: 0 pass, 1 register, 2 config, 3 out-of-range device
   task automatic predict(input bit wr, input logic [15:0] a, input logic [1:0] sz, input logic [31:0] wd,
                          output int kind, output logic [31:0] rv, output logic [29:0] fld);
      logic [7:0] bus; logic [4:0] dev; logic [2:0] fn; logic [7:0] rg;
      kind = 0; rv = '0; fld = '0; bus = '0; dev = '0; fn = '0; rg = '0;
      if (!m2) begin
         if (a[15:2] == 14'h33E) begin
            if (sz == 2'd2) begin
               kind = 1; rv = m_areg;
               if (wr) m_areg = wd & 32'h80FF_FFFF;
            end
         end else if (a[15:2] == 14'h33F && m_areg[31]) begin
            bus = m_areg[23:16]; dev = m_areg[15:11]; fn = m_areg[10:8];
            rg = {m_areg[7:2], 2'b00};
            kind = (int'(dev) > D1M) ? 3 : 2;
         end
      end else begin
         if (a == 16'hCF8 && sz == 2'd0) begin
            kind = 1; rv = {24'h0, m_key};
            if (wr) m_key = wd[7:0];
         end else if (a == 16'hCFA && sz == 2'd0) begin
            kind = 1; rv = {8'h0, m_fwd, 16'h0};
            if (wr) m_fwd = wd[23:16];
         end else if (a[15:2] == 14'h33E) begin
            kind = 0;
         end else if (a[15:12] == 4'hC && m_key[7:4] != 0) begin
            bus = m_fwd; dev = {1'b0, a[11:8]}; fn = m_key[3:1]; rg = {a[7:2], 2'b00};
            kind = (int'(dev) > D2M) ? 3 : 2;
         end
      end
      fld = {wr, (bus != 0), bus, dev, fn, rg, be_of(sz, a[1:0])};
   endtask

   // lat: ack after lat request cycles, 0 = never ack
   task automatic run(input bit wr, input logic [15:0] a, input logic [1:0] sz, input logic [31:0] wd,
                      input int lat, input logic [31:0] resp, input string tag);
      int kind; logic [31:0] rv, exp_rd; logic [29:0] fld, cap;
      bit fin; int guard;
      predict(wr, a, sz, wd, kind, rv, fld);
      @(negedge clk);
      io_req = 1'b1; io_wr = wr; io_addr = a; io_size = sz; io_wdata = wd;
      g_n = 0; fin = 0; guard = 0; cap = '0;
      while (!fin) begin
         @(negedge clk);
         io_req = 1'b0; cfg_ack = 1'b0;
         if (io_done) begin
            fin = 1; g_pass = io_pass; g_rd = io_rdata;
         end else begin
            if (cfg_req) begin
               g_n++;
               cap = {cfg_wr, cfg_type, cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_be};
               if (wr) chk(cfg_wdata == wd, {tag, " R4 wdata"}, cfg_wdata, wd);
               if (g_n == lat) begin cfg_ack = 1'b1; cfg_rdata = resp; end
            end
            guard++;
            if (guard > 60) begin
               chk(0, {tag, " R10 no completion"}, guard, 0);
               fin = 1; g_pass = 0; g_rd = 'x;
            end
         end
      end
      case (kind)
         0: exp_rd = 0;
         1: exp_rd = wr ? 0 : rv;
         2: exp_rd = wr ? 0 : (lat == 0 ? 32'hFFFF_FFFF : resp);
         default: exp_rd = wr ? 0 : 32'hFFFF_FFFF;
      endcase
      chk(g_pass == (kind == 0), {tag, " pass flag"}, g_pass, kind);
      chk(g_rd == exp_rd, {tag, " read data"}, g_rd, exp_rd);
      if (kind == 2) begin
         chk(cap == fld, {tag, " R4 R5 R8 fields"}, cap, fld);
         chk(g_n == (lat == 0 ? TO : lat), {tag, " R11 request length"}, g_n, lat);
      end else begin
         chk(g_n == 0, {tag, " R6 no request"}, g_n, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset(0);
      // R2 reset value and register access
      run(0, 16'hCF8, 2, 0, 1, 0, "R2 reset read");
      chk(g_rd == 32'h0, "R2 reset value", g_rd, 0);
      run(1, 16'hCF8, 2, 32'hFFFF_FFFC, 1, 0, "R2 write");
      run(0, 16'hCF8, 2, 0, 1, 0, "R2 readback");
      chk(g_rd == 32'h80FF_FFFC, "R2 reserved bits zero", g_rd, 32'h80FF_FFFC);
      // R6 device 31 above limit
      run(0, 16'hCFC, 2, 0, 1, 0, "R6 m1 device over limit");
      chk(g_rd == 32'hFFFF_FFFF, "R6 all ones", g_rd, 32'hFFFF_FFFF);
      // R3 narrow write at CFB passes and keeps enable
      run(1, 16'hCFB, 0, 0, 1, 0, "R3 byte write");
      chk(g_pass == 1'b1, "R3 pass", g_pass, 1);
      run(0, 16'hCF8, 2, 0, 1, 0, "R3 readback");
      chk(g_rd == 32'h80FF_FFFC, "R3 unchanged", g_rd, 32'h80FF_FFFC);
      run(1, 16'hCF8, 1, 0, 1, 0, "R3 word write");
      // R4 R5 R10 byte read, bus 0
      run(1, 16'hCF8, 2, 32'h8000_0A14, 1, 0, "R4 set address");
      run(0, 16'hCFE, 0, 0, 2, 32'hAABB_CCDD, "R4 R10 byte read");
      chk(g_rd == 32'hAABB_CCDD, "R10 ack data", g_rd, 32'hAABB_CCDD);
      // R4 R5 word write, bus 3, register low bits cleared
      run(1, 16'hCF8, 2, 32'h8003_0817, 1, 0, "R4 set address 2");
      run(1, 16'hCFE, 1, 32'h1234_0000, 1, 0, "R5 type1 word write");
      // R11 timeout
      run(0, 16'hCFC, 2, 0, 0, 0, "R11 timeout");
      chk(g_rd == 32'hFFFF_FFFF && g_n == TO, "R11 ones after timeout", {g_n, g_rd}, {TO, 32'hFFFF_FFFF});
      // R1 window belongs to the other scheme
      run(0, 16'hC100, 2, 0, 1, 0, "R1 m1 window pass");
      // R4 enable clear passes
      run(1, 16'hCF8, 2, 32'h0000_0A14, 1, 0, "R4 clear enable");
      run(0, 16'hCFC, 2, 0, 1, 0, "R4 disabled data pass");
      chk(g_pass == 1'b1, "R4 disabled pass", g_pass, 1);
      // R1 select change after reset has no effect
      mech2_sel = 1'b1;
      for (int i = 0; i < 60; i++) begin
         logic [15:0] a; logic [31:0] wd; logic [1:0] sz;
         wd = $urandom; sz = 2'($urandom % 3);
         case ($urandom % 4)
            0: begin a = 16'hCF8; sz = 2; wd = {($urandom % 4) != 0, 7'h0, 3'($urandom % 3), 5'($urandom % 24), 3'($urandom), 8'($urandom), 8'h0} | 32'(wd[7:0]); end
            1: a = 16'hCF8 + 16'($urandom % 4);
            2: a = 16'hCFC + 16'($urandom % 4);
            default: a = 16'hC000 | 16'($urandom % 4096);
         endcase
         run(($urandom % 2) == 1, a, sz, wd, ($urandom % 6), $urandom, "R1 R4 random m1");
      end

      do_reset(1);
      run(1, 16'hCF8, 2, 32'h8000_0000, 1, 0, "R1 m2 dword at port");
      chk(g_pass == 1'b1, "R1 m2 dword pass", g_pass, 1);
      run(0, 16'hCF8, 0, 0, 1, 0, "R7 key reset");
      chk(g_rd == 32'h0, "R7 key reset value", g_rd, 0);
      run(1, 16'hCF8, 0, 32'h0000_008B, 1, 0, "R7 key write");
      run(0, 16'hCF8, 0, 0, 1, 0, "R7 key readback");
      chk(g_rd == 32'h8B, "R7 key value", g_rd, 32'h8B);
      run(1, 16'hCFA, 0, 32'h0005_0000, 1, 0, "R7 forward write");
      run(0, 16'hCFA, 0, 0, 1, 0, "R7 forward readback");
      chk(g_rd == 32'h0005_0000, "R7 forward lane", g_rd, 32'h0005_0000);
      run(0, 16'hC316, 1, 0, 3, 32'h5566_7788, "R8 window word read");
      run(0, 16'hCD00, 2, 0, 1, 0, "R6 m2 device over limit");
      run(1, 16'hCF8, 0, 32'h0, 1, 0, "R9 close key");
      run(0, 16'hC200, 2, 0, 1, 0, "R9 closed window pass");
      chk(g_pass == 1'b1, "R9 pass", g_pass, 1);
      run(1, 16'hCF8, 0, 32'h10, 1, 0, "R5 key open");
      run(1, 16'hCFA, 0, 32'h0, 1, 0, "R5 forward zero");
      run(1, 16'hC004, 2, 32'hCAFE_F00D, 2, 0, "R5 type0 write");
      for (int i = 0; i < 60; i++) begin
         logic [15:0] a; logic [31:0] wd; logic [1:0] sz; bit w;
         wd = $urandom; sz = 2'($urandom % 3); w = ($urandom % 2) == 1;
         case ($urandom % 5)
            0: begin a = 16'hCF8; sz = 0; w = 1; end
            1: begin a = 16'hCFA; sz = 0; end
            2: a = 16'hCF8 + 16'($urandom % 4);
            default: a = 16'hC000 | 16'($urandom % 4096);
         endcase
         run(w, a, sz, wd, ($urandom % 6), $urandom, "R8 R9 random m2");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule